// File: doc/BRIEF.md
# Raster Timing Generator

The block drives the timing qualifiers of a display raster from the pixel clock. A horizontal counter runs down from a programmed line total to zero and reloads. Each time it reaches zero, a vertical counter steps down by one line. Eight window comparators look at these two counts and produce horizontal and vertical sync, blanking, active video and clock-enable qualifiers. The block also gives a strobe at the last clock of every line and of every frame.

Each window is one 32-bit register. It holds a start count in bits [15:0] and a stop count in bits [31:16]. Because the counters run downward, a window opens at its start count and closes when the count falls to its stop count. Software writes a shadow copy of every register through a simple write port. The whole set moves into the working copy only at the frame boundary, so a frame never mixes two timings. A control bit gates every output.

A typical programming for a display with a given active size, front porch, sync length and back porch is as follows. The total is the sum of the four, minus one. The sync window runs from the total down to the total minus the sync length. The blank and active windows both run from the total minus sync minus back porch, down to the front porch minus one. The intended range of active sizes is 64×64 to 1024×768.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_ni is low, every output is low. After reset both counters and all registers are zero.
- R2: The horizontal count goes down by one each clock from the line total to zero, then reloads. line_strobe_o is high in the cycle the horizontal count is zero.
- R3: The vertical count changes only in a cycle where the horizontal count is zero. In that cycle it steps down by one, or reloads to the frame total if it was already zero. frame_strobe_o is high when both counts are zero.
- R4: A window register holds start in bits [15:0] and stop in bits [31:16]. When stop < start, the window is open for counts c with stop < c <= start.
- R5: When stop >= start, the window wraps: it is open for c <= start or c > stop. Equal start and stop therefore keep it open for the whole period.
- R6: hsync_o follows the horizontal sync window. vsync_o follows the vertical sync window.
- R7: Each blank window describes the displayed span. hblank_o and vblank_o are high where their window is closed.
- R8: active_o is high when both the horizontal and the vertical active windows are open.
- R9: hclk_en_o and vclk_en_o follow the horizontal and vertical clock-enable windows.
- R10: A write goes to the shadow copy at once. The working copy, which drives all outputs and the counter totals, takes the shadow contents on the clock edge that ends a frame (both counts zero). The reloaded counts already use the new totals. A write on that same edge waits for the next frame boundary.
- R11: Control bit 0 is the enable. While the working enable is 0, all nine outputs are low.
- R12: Register addresses are: 0 control, 1 line total, 2 frame total, 3 h-sync, 4 h-blank, 5 h-active, 6 h-clock-enable, 7 v-sync, 8 v-blank, 9 v-active, 10 v-clock-enable. Totals use bits [15:0]. Writes to addresses 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync qualifier |
| vsync_o | output | 1 | Vertical sync qualifier |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| active_o | output | 1 | Active video |
| hclk_en_o | output | 1 | Horizontal clock-enable window |
| vclk_en_o | output | 1 | Vertical clock-enable window |
| line_strobe_o | output | 1 | Last clock of a line |
| frame_strobe_o | output | 1 | Last clock of a frame |

## Verification
A register write and the frame-boundary commit can fall in the same clock edge. The commit must then take the old shadow value, and the new value must wait a full frame. The bench steps a reference model until both counts are zero, then issues a window write in exactly that cycle. It compares every output, cycle by cycle, over the next two frames. Earlier mid-frame writes to a window and to the enable bit are judged the same way, against the model's separate pending and working register sets.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned FIELD_W  = 16;
  localparam int unsigned NUM_REGS = 11;
  localparam int unsigned WIN_BASE = 3;
  localparam int unsigned NUM_WIN  = NUM_REGS - WIN_BASE;

  typedef enum logic [3:0] {
    RA_CTRL    = 4'd0,
    RA_HTOTAL  = 4'd1,
    RA_VTOTAL  = 4'd2,
    RA_HSYNC   = 4'd3,
    RA_HBLANK  = 4'd4,
    RA_HACTIVE = 4'd5,
    RA_HCLKEN  = 4'd6,
    RA_VSYNC   = 4'd7,
    RA_VBLANK  = 4'd8,
    RA_VACTIVE = 4'd9,
    RA_VCLKEN  = 4'd10
  } reg_addr_e;

  // window slots, in register order after WIN_BASE
  typedef enum int unsigned {
    W_HSYNC = 0, W_HBLANK, W_HACTIVE, W_HCLKEN,
    W_VSYNC, W_VBLANK, W_VACTIVE, W_VCLKEN
  } win_idx_e;
endpackage

// File: rtl/raster_regs.sv
module raster_regs #(
  parameter int unsigned NREGS = 11,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       commit_i,
  output logic [NREGS-1:0][DW-1:0]   cur_o,
  output logic [NREGS-1:0][DW-1:0]   nxt_o
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [DW-1:0] shd_q;
    logic [DW-1:0] cur_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q <= '0;
        cur_q <= '0;
      end else begin
        if (wr_en_i && (wr_addr_i == AW'(i))) shd_q <= wr_data_i;
        if (commit_i) cur_q <= shd_q;
      end
    end

    assign cur_o[i] = cur_q;
    // value the working copy holds after this edge
    assign nxt_o[i] = commit_i ? shd_q : cur_q;
  end
endmodule

// File: rtl/raster_down_counter.sv
module raster_down_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/raster_window.sv
module raster_window #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] stop_i,
  output logic         open_o
);
  logic below_start, above_stop, wraps;

  assign below_start = (cnt_i <= start_i);
  assign above_stop  = (cnt_i > stop_i);
  // stop at or past start: window spans the reload point
  assign wraps       = (stop_i >= start_i);
  assign open_o      = wraps ? (below_start | above_stop) : (below_start & above_stop);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          active_o,
  output logic          hclk_en_o,
  output logic          vclk_en_o,
  output logic          line_strobe_o,
  output logic          frame_strobe_o
);
  localparam int unsigned NREGS = NUM_REGS;
  localparam int unsigned NWIN  = NUM_WIN;
  localparam int unsigned NHWIN = NWIN / 2;

  logic [NREGS-1:0][DW-1:0] cur_w;
  logic [NREGS-1:0][DW-1:0] nxt_w;
  logic [CNT_W-1:0]         h_cnt, v_cnt;
  logic                     h_zero, v_zero, frame_end;
  logic [NWIN-1:0]          win_open;
  logic                     en;
  logic [CNT_W-1:0]         cur_htotal, cur_vtotal;
  logic [8:0]               out_vec;
  logic                     unused_bits;

  assign frame_end = h_zero & v_zero;

  raster_regs #(.NREGS(NREGS), .AW(AW), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .commit_i  (frame_end),
    .cur_o     (cur_w),
    .nxt_o     (nxt_w)
  );

  raster_down_counter #(.W(CNT_W)) u_hcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (1'b1),
    .reload_i (nxt_w[RA_HTOTAL][CNT_W-1:0]),
    .cnt_o    (h_cnt),
    .zero_o   (h_zero)
  );

  raster_down_counter #(.W(CNT_W)) u_vcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (h_zero),
    .reload_i (nxt_w[RA_VTOTAL][CNT_W-1:0]),
    .cnt_o    (v_cnt),
    .zero_o   (v_zero)
  );

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    localparam int unsigned RI = WIN_BASE + k;
    logic [CNT_W-1:0] sel_cnt;
    if (k < NHWIN) begin : g_h
      assign sel_cnt = h_cnt;
    end else begin : g_v
      assign sel_cnt = v_cnt;
    end
    raster_window #(.W(CNT_W)) u_win (
      .cnt_i   (sel_cnt),
      .start_i (cur_w[RI][CNT_W-1:0]),
      .stop_i  (cur_w[RI][FIELD_W +: CNT_W]),
      .open_o  (win_open[k])
    );
  end

  assign en         = cur_w[RA_CTRL][0];
  assign cur_htotal = cur_w[RA_HTOTAL][CNT_W-1:0];
  assign cur_vtotal = cur_w[RA_VTOTAL][CNT_W-1:0];

  assign hsync_o        = en &  win_open[W_HSYNC];
  assign vsync_o        = en &  win_open[W_VSYNC];
  assign hblank_o       = en & ~win_open[W_HBLANK];
  assign vblank_o       = en & ~win_open[W_VBLANK];
  assign active_o       = en &  win_open[W_HACTIVE] & win_open[W_VACTIVE];
  assign hclk_en_o      = en &  win_open[W_HCLKEN];
  assign vclk_en_o      = en &  win_open[W_VCLKEN];
  assign line_strobe_o  = en &  h_zero;
  assign frame_strobe_o = en &  frame_end;

  assign out_vec = {hsync_o, vsync_o, hblank_o, vblank_o, active_o,
                    hclk_en_o, vclk_en_o, line_strobe_o, frame_strobe_o};

  assign unused_bits = ^{cur_w[RA_CTRL][DW-1:1], cur_w[RA_HTOTAL][DW-1:CNT_W],
                         cur_w[RA_VTOTAL][DW-1:CNT_W], nxt_w, out_vec};
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] h_cnt_i,
  input logic [CNT_W-1:0] v_cnt_i,
  input logic [CNT_W-1:0] cur_htotal_i,
  input logic [CNT_W-1:0] cur_vtotal_i,
  input logic             en_i,
  input logic [8:0]       outs_i,
  input logic             line_i,
  input logic             frame_i
);
  logic at_end;
  assign at_end = (h_cnt_i == '0) && (v_cnt_i == '0);

  p_hcount_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt_i != '0) |=> (h_cnt_i == $past(h_cnt_i) - 1'b1));

  p_line_at_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_i |-> (h_cnt_i == '0));

  p_vhold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt_i != '0) |=> $stable(v_cnt_i));

  p_frame_is_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |-> line_i);

  p_frame_reload_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_end |=> ((h_cnt_i == cur_htotal_i) && (v_cnt_i == cur_vtotal_i)));

  p_commit_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_end |=> ($stable(cur_htotal_i) && $stable(en_i)));

  p_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (outs_i == '0));
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .h_cnt_i      (h_cnt),
  .v_cnt_i      (v_cnt),
  .cur_htotal_i (cur_htotal),
  .cur_vtotal_i (cur_vtotal),
  .en_i         (en),
  .outs_i       (out_vec),
  .line_i       (line_strobe_o),
  .frame_i      (frame_strobe_o)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic hsync, vsync, hblank, vblank, active, hce, vce, lstb, fstb;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  logic [31:0] pend [11];
  logic [31:0] cur  [11];
  int mh = 0;
  int mv = 0;

  always #5 clk = ~clk;

  raster_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hsync), .vsync_o(vsync), .hblank_o(hblank),
    .vblank_o(vblank), .active_o(active), .hclk_en_o(hce), .vclk_en_o(vce),
    .line_strobe_o(lstb), .frame_strobe_o(fstb)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog (R1 onward) act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  function automatic bit win(int c, logic [31:0] r);
    int s = int'(r[15:0]);
    int p = int'(r[31:16]);
    if (p >= s) return (c <= s) || (c > p);
    return (c <= s) && (c > p);
  endfunction

  task automatic check(string tag, string ph, string nm, logic act, logic exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s [%s] %s act=%b exp=%b t=%0t", tag, ph, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all(string ph);
    bit en = cur[0][0];
    check("R6", ph, "hsync",  hsync,  en & win(mh, cur[3]));
    check("R7", ph, "hblank", hblank, en & !win(mh, cur[4]));
    check("R8", ph, "active", active, en & win(mh, cur[5]) & win(mv, cur[9]));
    check("R9", ph, "hce",    hce,    en & win(mh, cur[6]));
    check("R6", ph, "vsync",  vsync,  en & win(mv, cur[7]));
    check("R7", ph, "vblank", vblank, en & !win(mv, cur[8]));
    check("R9", ph, "vce",    vce,    en & win(mv, cur[10]));
    check("R2", ph, "line",   lstb,   en & (mh == 0));
    check("R3", ph, "frame",  fstb,   en & (mh == 0) & (mv == 0));
  endtask

  task automatic step_model(bit we, int a, logic [31:0] d);
    bit fe = (mh == 0) && (mv == 0);
    if (mh == 0) begin
      mh = fe ? int'(pend[1][15:0]) : int'(cur[1][15:0]);
      if (mv == 0) mv = int'(pend[2][15:0]);
      else mv = mv - 1;
    end else begin
      mh = mh - 1;
    end
    if (fe) for (int i = 0; i < 11; i++) cur[i] = pend[i];
    if (we && a < 11) pend[a] = d;
  endtask

  task automatic tick(bit we, int a, logic [31:0] d, string ph);
    wr_en = we; wr_addr = a[3:0]; wr_data = d;
    @(posedge clk);
    step_model(we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    compare_all(ph);
  endtask

  task automatic run(int n, string ph);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 32'h0, ph);
  endtask

  function automatic logic [31:0] pk(int start, int stop);
    return {stop[15:0], start[15:0]};
  endfunction

  initial begin
    for (int i = 0; i < 11; i++) begin pend[i] = '0; cur[i] = '0; end
    rst_ni = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: all outputs low in reset
    check("R1", "reset", "hsync", hsync, 1'b0);
    check("R1", "reset", "vsync", vsync, 1'b0);
    check("R1", "reset", "hblank", hblank, 1'b0);
    check("R1", "reset", "vblank", vblank, 1'b0);
    check("R1", "reset", "active", active, 1'b0);
    check("R1", "reset", "hce", hce, 1'b0);
    check("R1", "reset", "vce", vce, 1'b0);
    check("R1", "reset", "line", lstb, 1'b0);
    check("R1", "reset", "frame", fstb, 1'b0);
    rst_ni = 1'b1;
    run(2, "R1");

    // R12 map; H: act 8 fp 2 sync 3 bp 2 -> 14; V: act 4 fp 1 sync 2 bp 1 -> 7
    tick(1, 1, 32'd14, "R12");
    tick(1, 2, 32'd7, "R12");
    tick(1, 3, pk(14, 11), "R12");
    tick(1, 4, pk(9, 1), "R12");
    tick(1, 5, pk(9, 1), "R12");
    tick(1, 6, pk(14, 14), "R12");
    tick(1, 7, pk(7, 5), "R12");
    tick(1, 8, pk(4, 0), "R12");
    tick(1, 9, pk(4, 0), "R12");
    tick(1, 10, pk(7, 8), "R12");
    tick(1, 0, 32'd1, "R12");
    run(3 * 15 * 8, "R4");

    // R12: out-of-map writes change nothing
    tick(1, 11, 32'hFFFF_FFFF, "R12");
    tick(1, 15, 32'h0000_0000, "R12");
    run(2 * 120, "R12");

    // R10: mid-frame window change waits for boundary
    run(37, "R10");
    tick(1, 3, pk(14, 13), "R10");
    run(2 * 120, "R10");

    // R10: write on the frame-end edge waits one more frame
    while (!((mh == 0) && (mv == 0))) tick(1'b0, 0, 32'h0, "R10");
    tick(1, 3, pk(14, 10), "R10");
    run(2 * 120, "R10");

    // R5: wrapping and full windows
    tick(1, 4, pk(3, 10), "R5");
    tick(1, 5, pk(5, 5), "R5");
    tick(1, 8, pk(1, 6), "R5");
    run(2 * 120, "R5");

    // R11: disable then re-enable
    tick(1, 0, 32'd0, "R11");
    run(2 * 120, "R11");
    tick(1, 0, 32'd1, "R11");
    run(2 * 120, "R11");

    // R2 R3: new totals 9 and 3 take effect at boundary
    tick(1, 1, 32'd9, "R2");
    tick(1, 2, 32'd3, "R3");
    tick(1, 3, pk(9, 7), "R2");
    tick(1, 7, pk(3, 2), "R3");
    run(120 + 3 * 40, "R3");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule